// File: doc/BRIEF.md
# Three-Stage Pipeline Stall Controller

This block makes the per-cycle advance decisions for a fetch, decode and execute pipeline in a small 32-bit processor core. Each cycle it looks at a global run enable, memory readiness, the bus arrangement and the operand dependencies between the load in execute and the instruction in decode. From these it decides whether each stage captures new contents, holds what it has, or takes an empty slot. The controller is purely combinational. Its outputs drive the load enables of the pipeline registers and the muxes that insert empty slots.

A freeze stops the whole core: every stage holds, and no squash, flush or bubble is applied. A freeze can come from the enable pin being low (power saving), from a memory that has not yet returned a read, or from the single shared bus not yet delivering. A redirect from execute (a taken branch or an exception entry) flushes fetch and decode. Next in priority, a dependent instruction behind a load is held back for exactly one cycle, and an empty slot goes into execute in its place. On a shared bus, a data access that completes takes the fetch slot, and that cycle is handled the same way.

Top module: `pipe_stall_ctrl`

## Requirements
- R1: While `core_en` is low, all six outputs (`fe_adv`, `de_adv`, `ex_adv`, `de_squash`, `ex_bubble`, `fe_flush`) are 0, whatever the other inputs are.
- R2: With `shared_bus` low, the core freezes (all outputs 0) when `imem_rdy` is low, or when `dmem_req` is high and `dmem_rdy` is low.
- R3: With `shared_bus` high and `dmem_req` high, the freeze follows only `dmem_rdy` (low freezes) and `imem_rdy` has no effect. With `dmem_req` low, the freeze follows only `imem_rdy`.
- R4: With `shared_bus` high, `dmem_req` and `dmem_rdy` high, `core_en` high and no redirect, the outputs are the hold pattern: `fe_adv`=0, `de_adv`=0, `ex_adv`=1, `de_squash`=1, `ex_bubble`=1, `fe_flush`=0.
- R5: A load-use hazard produces the hold pattern of R4 when the core is not frozen and there is no redirect. A hazard exists when `ex_is_load`=1, `de_valid`=1, and some source k has `de_src_used[k]`=1 and `de_src_idx[4k+3:4k]` equal to `ex_ld_dst`.
- R6: A source whose used bit is 0, a `de_valid` of 0 or an `ex_is_load` of 0 never makes a hazard. With no hazard, no redirect, no freeze and no shared-bus data access, the outputs are `fe_adv`=`de_adv`=`ex_adv`=1 and the other three are 0.
- R7: A match on source 1 alone (bits 7:4), with source 0 not matching, is a hazard just as a match on source 0 is.
- R8: When `ex_redirect` is high and the core is not frozen, all six outputs are 1. This holds whether or not a load-use hazard or a shared-bus data access is present.
- R9: A freeze takes priority over hazards and redirects. When the freeze releases with the same inputs, the held hazard pattern of R5 appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, samples the embedded properties only |
| rst_n | input | 1 | Active-low reset, disables the properties |
| core_en | input | 1 | Global run enable; low freezes the core |
| imem_rdy | input | 1 | Instruction read data available |
| dmem_rdy | input | 1 | Data read/write complete |
| shared_bus | input | 1 | One bus carries both instruction and data traffic |
| dmem_req | input | 1 | Execute stage has a data access in progress |
| ex_redirect | input | 1 | Taken branch or exception entry from execute |
| ex_is_load | input | 1 | Instruction in execute is a load |
| ex_ld_dst | input | REG_IDX_W (4) | Destination register of that load |
| de_valid | input | 1 | Decode holds a real instruction |
| de_src_idx | input | NUM_SRC*REG_IDX_W (8) | Decode source indices, source k at bits [4k+3:4k] |
| de_src_used | input | NUM_SRC (2) | Bit k set when source k is read |
| fe_adv | output | 1 | Fetch register captures new instruction |
| de_adv | output | 1 | Decode register captures from fetch |
| ex_adv | output | 1 | Execute register captures from decode |
| de_squash | output | 1 | Decode instruction is not issued this cycle |
| ex_bubble | output | 1 | Execute captures an empty slot |
| fe_flush | output | 1 | Fetch output discarded, new target fetched |

## Verification
The random stimulus biases load destinations and source indices into a small range, so matches on each source, on both sources and on none all occur often. Each random pattern is set against the independent expected value, and the cases are sorted by the deciding input. This tells a freeze from either bus arrangement apart from a hold and a redirect. Directed sequences cover the rest. A freeze that arrives during a load must release into the hold. Two back-to-back dependent loads must each cost one cycle. A match on the second operand only must be caught. A redirect in the same cycle as a hazard must override the hold.

// File: rtl/pipe_stall_pkg.sv
package pipe_stall_pkg;

   // Per-stage control bundle, ordered as the top module's outputs.
   typedef struct packed {
      logic fe_adv;
      logic de_adv;
      logic ex_adv;
      logic de_squash;
      logic ex_bubble;
      logic fe_flush;
   } stage_ctl_t;

   localparam stage_ctl_t CTL_FROZEN   = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
   localparam stage_ctl_t CTL_RUN      = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
   localparam stage_ctl_t CTL_HOLD     = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
   localparam stage_ctl_t CTL_REDIRECT = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

endpackage

// File: rtl/pipe_ldu_detect.sv
module pipe_ldu_detect #(
   parameter int REG_IDX_W = 4,
   parameter int NUM_SRC   = 2
) (
   input  logic                          ex_is_load,
   input  logic [REG_IDX_W-1:0]          ex_ld_dst,
   input  logic                          de_valid,
   input  logic [NUM_SRC*REG_IDX_W-1:0]  de_src_idx,
   input  logic [NUM_SRC-1:0]            de_src_used,
   output logic                          hazard
);

   localparam int IDX_BITS = NUM_SRC * REG_IDX_W;

   if (REG_IDX_W < 1) begin : g_bad_w
      $error("pipe_ldu_detect: REG_IDX_W must be at least 1");
   end
   if (NUM_SRC < 1) begin : g_bad_n
      $error("pipe_ldu_detect: NUM_SRC must be at least 1");
   end

   logic [NUM_SRC-1:0] src_hit;

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      assign src_hit[k] = de_src_used[k] &&
                          (de_src_idx[k*REG_IDX_W +: REG_IDX_W] == ex_ld_dst);
   end

   assign hazard = ex_is_load && de_valid && (|src_hit);

   // Unused IDX_BITS keeps the derived width visible to readers.
   logic unused_w;
   assign unused_w = (IDX_BITS == 0);

endmodule

// File: rtl/pipe_freeze_ctrl.sv
module pipe_freeze_ctrl #(
   parameter bit HAS_SHARED_BUS = 1'b1
) (
   input  logic core_en,
   input  logic imem_rdy,
   input  logic dmem_rdy,
   input  logic shared_bus,
   input  logic dmem_req,
   output logic frz,
   output logic slot_taken
);

   logic bus_wait;

   if (HAS_SHARED_BUS) begin : g_shared
      logic shared_wait;
      logic split_wait;
      assign shared_wait = dmem_req ? !dmem_rdy : !imem_rdy;
      assign split_wait  = !imem_rdy || (dmem_req && !dmem_rdy);
      assign bus_wait    = shared_bus ? shared_wait : split_wait;
      // A finished data access on the one bus took the fetch slot.
      assign slot_taken  = shared_bus && dmem_req && dmem_rdy;
   end else begin : g_split
      logic unused_sb;
      assign unused_sb  = shared_bus;
      assign bus_wait   = !imem_rdy || (dmem_req && !dmem_rdy);
      assign slot_taken = 1'b0;
   end

   assign frz = !core_en || bus_wait;

endmodule

// File: rtl/pipe_stall_ctrl.sv
module pipe_stall_ctrl
   import pipe_stall_pkg::*;
#(
   parameter int REG_IDX_W      = 4,
   parameter int NUM_SRC        = 2,
   parameter bit HAS_SHARED_BUS = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          core_en,
   input  logic                          imem_rdy,
   input  logic                          dmem_rdy,
   input  logic                          shared_bus,
   input  logic                          dmem_req,
   input  logic                          ex_redirect,
   input  logic                          ex_is_load,
   input  logic [REG_IDX_W-1:0]          ex_ld_dst,
   input  logic                          de_valid,
   input  logic [NUM_SRC*REG_IDX_W-1:0]  de_src_idx,
   input  logic [NUM_SRC-1:0]            de_src_used,
   output logic                          fe_adv,
   output logic                          de_adv,
   output logic                          ex_adv,
   output logic                          de_squash,
   output logic                          ex_bubble,
   output logic                          fe_flush
);

   logic       frz;
   logic       slot_taken;
   logic       ldu_hz;
   stage_ctl_t ctl;

   pipe_freeze_ctrl #(
      .HAS_SHARED_BUS (HAS_SHARED_BUS)
   ) freeze_i (
      .core_en    (core_en),
      .imem_rdy   (imem_rdy),
      .dmem_rdy   (dmem_rdy),
      .shared_bus (shared_bus),
      .dmem_req   (dmem_req),
      .frz        (frz),
      .slot_taken (slot_taken)
   );

   pipe_ldu_detect #(
      .REG_IDX_W (REG_IDX_W),
      .NUM_SRC   (NUM_SRC)
   ) ldu_i (
      .ex_is_load  (ex_is_load),
      .ex_ld_dst   (ex_ld_dst),
      .de_valid    (de_valid),
      .de_src_idx  (de_src_idx),
      .de_src_used (de_src_used),
      .hazard      (ldu_hz)
   );

   // Priority: freeze, then redirect, then hold, then run.
   always_comb begin
      if (frz)                       ctl = CTL_FROZEN;
      else if (ex_redirect)          ctl = CTL_REDIRECT;
      else if (ldu_hz || slot_taken) ctl = CTL_HOLD;
      else                           ctl = CTL_RUN;
   end

   assign fe_adv    = ctl.fe_adv;
   assign de_adv    = ctl.de_adv;
   assign ex_adv    = ctl.ex_adv;
   assign de_squash = ctl.de_squash;
   assign ex_bubble = ctl.ex_bubble;
   assign fe_flush  = ctl.fe_flush;

   // R1: a low enable leaves every stage untouched.
   p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !core_en |-> !(fe_adv || de_adv || ex_adv || de_squash || ex_bubble || fe_flush));

   // R8: a redirect outside a freeze flushes both front stages.
   p_redirect_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_redirect && !frz) |-> (fe_flush && de_squash && ex_bubble && fe_adv));

   // R5: a detected hazard with no redirect holds the front end.
   p_hazard_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ldu_hz && !frz && !ex_redirect) |-> (de_squash && !fe_adv && !de_adv && ex_bubble));

   // R4: an empty slot into execute only when execute captures.
   p_bubble_needs_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ex_bubble |-> ex_adv);

   // R9: a freeze blocks every squash and flush.
   p_freeze_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frz |-> !(de_squash || fe_flush || ex_bubble));

endmodule

// File: tb/pipe_stall_ctrl_tb.sv
module pipe_stall_ctrl_tb_top;

   localparam int W = 4;
   localparam int N = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic core_en = 1'b0, imem_rdy = 1'b0, dmem_rdy = 1'b0;
   logic shared_bus = 1'b0, dmem_req = 1'b0, ex_redirect = 1'b0;
   logic ex_is_load = 1'b0, de_valid = 1'b0;
   logic [W-1:0]   ex_ld_dst = '0;
   logic [N*W-1:0] de_src_idx = '0;
   logic [N-1:0]   de_src_used = '0;
   logic fe_adv, de_adv, ex_adv, de_squash, ex_bubble, fe_flush;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;   // 50 MHz

   pipe_stall_ctrl dut_i (
      .clk (clk), .rst_n (rst_n), .core_en (core_en),
      .imem_rdy (imem_rdy), .dmem_rdy (dmem_rdy),
      .shared_bus (shared_bus), .dmem_req (dmem_req),
      .ex_redirect (ex_redirect), .ex_is_load (ex_is_load),
      .ex_ld_dst (ex_ld_dst), .de_valid (de_valid),
      .de_src_idx (de_src_idx), .de_src_used (de_src_used),
      .fe_adv (fe_adv), .de_adv (de_adv), .ex_adv (ex_adv),
      .de_squash (de_squash), .ex_bubble (ex_bubble), .fe_flush (fe_flush)
   );

   localparam logic [5:0] E_FROZEN = 6'b000000;
   localparam logic [5:0] E_RUN    = 6'b111000;
   localparam logic [5:0] E_HOLD   = 6'b001110;
   localparam logic [5:0] E_REDIR  = 6'b111111;

   function automatic logic ref_hazard();
      logic hit = 1'b0;
      for (int k = 0; k < N; k++)
         if (de_src_used[k] && de_src_idx[k*W +: W] == ex_ld_dst) hit = 1'b1;
      return ex_is_load && de_valid && hit;
   endfunction

   function automatic logic ref_freeze();
      if (!core_en) return 1'b1;
      if (shared_bus) return dmem_req ? !dmem_rdy : !imem_rdy;
      return !imem_rdy || (dmem_req && !dmem_rdy);
   endfunction

   function automatic logic [5:0] ref_ctl();
      if (ref_freeze()) return E_FROZEN;
      if (ex_redirect) return E_REDIR;
      if (ref_hazard() || (shared_bus && dmem_req)) return E_HOLD;
      return E_RUN;
   endfunction

   function automatic string ref_req();
      if (!core_en) return "R1";
      if (ref_freeze()) return shared_bus ? "R3" : "R2";
      if (ex_redirect) return "R8";
      if (ref_hazard()) return "R5";
      if (shared_bus && dmem_req) return "R4";
      return "R6";
   endfunction

   task automatic check(input string req, input logic [5:0] exp);
      logic [5:0] act;
      act = {fe_adv, de_adv, ex_adv, de_squash, ex_bubble, fe_flush};
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: outputs %b, expected %b", req, act, exp);
      end
   endtask

   // Drive on falling edge, sample a quarter period later.
   task automatic settle();
      @(negedge clk);
      #5;
   endtask

   task automatic set_base();
      core_en = 1'b1; imem_rdy = 1'b1; dmem_rdy = 1'b1;
      shared_bus = 1'b0; dmem_req = 1'b0; ex_redirect = 1'b0;
      ex_is_load = 1'b0; ex_ld_dst = '0; de_valid = 1'b1;
      de_src_idx = '0; de_src_used = '0;
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      process::self().srandom(32'd1357);
      // Reset state: enable low, outputs quiet (R1).
      settle();
      check("R1", E_FROZEN);
      repeat (2) @(posedge clk);
      rst_n = 1'b1;

      // R6 normal run.
      set_base(); settle(); check("R6", E_RUN);

      // R5 load-use on source 0.
      ex_is_load = 1'b1; ex_ld_dst = 4'd3;
      de_src_idx = {4'd9, 4'd3}; de_src_used = 2'b01;
      settle(); check("R5", E_HOLD);

      // R6 same match but operand unused.
      de_src_used = 2'b10; settle(); check("R6", E_RUN);

      // R7 match on second operand only.
      de_src_idx = {4'd3, 4'd8}; de_src_used = 2'b11;
      settle(); check("R7", E_HOLD);

      // R9 freeze during load, then release.
      imem_rdy = 1'b0; settle(); check("R9", E_FROZEN);
      core_en = 1'b0; imem_rdy = 1'b1; settle(); check("R9", E_FROZEN);
      core_en = 1'b1; settle(); check("R9", E_HOLD);

      // Back-to-back dependent loads: hold, run, hold.
      ex_is_load = 1'b0; settle(); check("R6", E_RUN);
      ex_is_load = 1'b1; ex_ld_dst = 4'd5;
      de_src_idx = {4'd1, 4'd5}; de_src_used = 2'b01;
      settle(); check("R5", E_HOLD);
      ex_is_load = 1'b0; settle(); check("R6", E_RUN);

      // R8 redirect in same cycle as hazard.
      ex_is_load = 1'b1; ex_redirect = 1'b1; settle(); check("R8", E_REDIR);
      ex_redirect = 1'b0;

      // R6 decode empty: no hazard.
      de_valid = 1'b0; settle(); check("R6", E_RUN);

      // R2 split bus data wait.
      set_base(); dmem_req = 1'b1; dmem_rdy = 1'b0; settle(); check("R2", E_FROZEN);

      // R3 shared bus: imem_rdy ignored while data access pending.
      shared_bus = 1'b1; dmem_rdy = 1'b1; imem_rdy = 1'b0;
      settle(); check("R3", E_HOLD);
      // R4 shared-bus slot taken.
      imem_rdy = 1'b1; settle(); check("R4", E_HOLD);
      dmem_req = 1'b0; imem_rdy = 1'b0; settle(); check("R3", E_FROZEN);

      // Random patterns.
      for (int i = 0; i < 600; i++) begin
         core_en     = ($urandom % 8) != 0;
         imem_rdy    = ($urandom % 5) != 0;
         dmem_rdy    = ($urandom % 4) != 0;
         shared_bus  = $urandom % 2;
         dmem_req    = ($urandom % 3) == 0;
         ex_redirect = ($urandom % 6) == 0;
         ex_is_load  = $urandom % 2;
         ex_ld_dst   = W'($urandom % 4);
         de_valid    = ($urandom % 5) != 0;
         de_src_idx  = {W'($urandom % 4), W'($urandom % 4)};
         de_src_used = N'($urandom);
         settle();
         check(ref_req(), ref_ctl());
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule